// File: doc/BRIEF.md
# Erase Command Order Checker

This block watches the decoded command stream of a storage card and enforces the three-step erase order: a start-address command (index 32), then an end-address command (index 33), then the erase command (index 38). Each address argument is a byte address. The block turns it into a block index by discarding the bits below the current write block length, which is given as a base-2 logarithm. It holds the start and end block indices between commands. When the order is completed, it issues a one-cycle erase request that carries the range.

The block tells apart two kinds of sequence violation. An erase-class command that arrives in the wrong place sets the sequence-error flag and clears the sequence. Any other command that arrives while a sequence is open sets the erase-reset flag, clears the sequence and is still passed on for execution. The status-poll command (index 13) leaves the sequence as it is and clears both flags.

During an erase, the block walks the range one block per cycle through an external write-protect lookup. It reports each protected block as skipped and sets a sticky skip flag. Busy, meaning the data line is held low, stays asserted until the flash side signals completion.

Top module: `erase_seq_ctrl`

## Requirements
- R1: Index 32 in the idle state latches the start block. Index 33 with only a start held latches the end block. Index 38 with both held pulses `erase_req` for one cycle, in the cycle after the command, with `erase_first`/`erase_last` set to the latched start and end blocks.
- R2: Index 32 while a start is already held, index 33 without a start held, or index 38 without an end held sets `stat_seq_err` and returns the sequence to idle. None of these produces an erase request.
- R3: Any command other than 13, 32, 33 or 38 that arrives while a sequence is open sets `stat_erase_rst` and returns the sequence to idle. Every command other than 32, 33 and 38 pulses `cmd_exec` one cycle later.
- R4: Index 13 does not change the sequence state. Both sequence flags read 0 in the cycle after it.
- R5: The block index is the byte address shifted right by `blk_len_log2`.
- R6: After an erase request, `wp_addr` walks from the first block to the last block, one block per cycle. For each block where `wp_hit` is 1, the block emits a one-cycle `skip_valid` with `skip_blk` equal to that block, in ascending order, and sets `stat_wp_skip`. Only index 13 clears `stat_wp_skip`.
- R7: `busy` rises together with `erase_req`. It falls only in the cycle after an `erase_done` pulse that arrives once the walk has finished. An `erase_done` pulse during the walk, or while the block is idle, has no effect.
- R8: While `busy` is 1, index 32, 33 or 38 sets `stat_seq_err` and never starts a new erase.
- R9: Synchronous reset clears the sequence, all three flags, `busy` and the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | ARG_W | Command argument (byte address for 32/33) |
| blk_len_log2 | input | SHIFT_W | log2 of the write block length in bytes |
| wp_addr | output | BLK_W | Block under write-protect lookup |
| wp_hit | input | 1 | Lookup answer for `wp_addr`, same cycle |
| erase_done | input | 1 | Flash erase completion strobe |
| erase_req | output | 1 | One-cycle erase request |
| erase_first | output | BLK_W | First block of the request |
| erase_last | output | BLK_W | Last block of the request |
| cmd_exec | output | 1 | Pulse: command passed on for execution |
| busy | output | 1 | Erase in progress (data line held low) |
| skip_valid | output | 1 | Pulse: a protected block was skipped |
| skip_blk | output | BLK_W | Index of the skipped block |
| stat_seq_err | output | 1 | Sticky sequence-error flag |
| stat_erase_rst | output | 1 | Sticky erase-reset flag |
| stat_wp_skip | output | 1 | Sticky protected-skip flag |

## Verification
The bench probes each ordering trap. These are a repeated start command, an end or erase command with no start, a stray read or write in the middle of an open sequence, and a status poll placed between the steps. A design that mixed up the two flags, or that let the poll reset the sequence, would raise the wrong bit or reject the next step. Two erases at different block lengths check the address truncation and the order of the skip reports. A wrong shift or a walk that is off by one would show up as a wrong range or a missing skip. The bench also sends a completion strobe during the walk, an erase command while busy, and a reset between the start and end commands. A design that dropped busy early, accepted a second erase, or kept the start across reset would be caught.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE       = 2'd0,
    SQ_HAVE_START = 2'd1,
    SQ_HAVE_END   = 2'd2
  } seq_state_e;

  localparam logic [5:0] IDX_STATUS = 6'd13;
  localparam logic [5:0] IDX_START  = 6'd32;
  localparam logic [5:0] IDX_END    = 6'd33;
  localparam logic [5:0] IDX_ERASE  = 6'd38;

  localparam int unsigned FLAG_SEQ  = 0;
  localparam int unsigned FLAG_RST  = 1;
  localparam int unsigned FLAG_SKIP = 2;
  localparam int unsigned NFLAGS    = 3;
endpackage

// File: rtl/erase_addr_norm.sv
module erase_addr_norm #(
  parameter int ARG_W   = 32,
  parameter int BLK_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic [ARG_W-1:0]   byte_addr,
  input  logic [SHIFT_W-1:0] shift,
  output logic [BLK_W-1:0]   blk_idx
);
  logic [ARG_W-1:0] shifted;
  assign shifted = byte_addr >> shift;
  assign blk_idx = shifted[BLK_W-1:0];
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
  import erase_seq_pkg::*;
#(
  parameter int BLK_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [5:0]       cmd_index,
  input  logic [BLK_W-1:0] norm_blk,
  input  logic             busy,
  output logic             launch,
  output logic [BLK_W-1:0] start_blk,
  output logic [BLK_W-1:0] end_blk,
  output logic             set_seq_err,
  output logic             set_erase_rst,
  output logic             status_clr,
  output logic             erase_req,
  output logic [BLK_W-1:0] erase_first,
  output logic [BLK_W-1:0] erase_last,
  output logic             cmd_exec
);
  seq_state_e state_q, state_d;
  logic is_start, is_end, is_erase, is_status, is_erase_cls, is_other;
  logic take_start, take_end;

  assign is_start     = cmd_valid && (cmd_index == IDX_START);
  assign is_end       = cmd_valid && (cmd_index == IDX_END);
  assign is_erase     = cmd_valid && (cmd_index == IDX_ERASE);
  assign is_status    = cmd_valid && (cmd_index == IDX_STATUS);
  assign is_erase_cls = is_start || is_end || is_erase;
  assign is_other     = cmd_valid && !is_erase_cls && !is_status;
  assign status_clr   = is_status;

  always_comb begin
    state_d       = state_q;
    set_seq_err   = 1'b0;
    set_erase_rst = 1'b0;
    launch        = 1'b0;
    take_start    = 1'b0;
    take_end      = 1'b0;
    if (is_erase_cls && busy) begin
      set_seq_err = 1'b1;
      state_d     = SQ_IDLE;
    end else if (is_start) begin
      if (state_q == SQ_IDLE) begin
        take_start = 1'b1;
        state_d    = SQ_HAVE_START;
      end else begin
        set_seq_err = 1'b1;
        state_d     = SQ_IDLE;
      end
    end else if (is_end) begin
      if (state_q == SQ_HAVE_START) begin
        take_end = 1'b1;
        state_d  = SQ_HAVE_END;
      end else begin
        set_seq_err = 1'b1;
        state_d     = SQ_IDLE;
      end
    end else if (is_erase) begin
      if (state_q == SQ_HAVE_END) begin
        launch = 1'b1;
      end else begin
        set_seq_err = 1'b1;
      end
      state_d = SQ_IDLE;
    end else if (is_other && (state_q != SQ_IDLE)) begin
      set_erase_rst = 1'b1;
      state_d       = SQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      start_blk   <= '0;
      end_blk     <= '0;
      erase_req   <= 1'b0;
      erase_first <= '0;
      erase_last  <= '0;
      cmd_exec    <= 1'b0;
    end else begin
      state_q   <= state_d;
      erase_req <= launch;
      cmd_exec  <= cmd_valid && !is_erase_cls;
      if (take_start) start_blk <= norm_blk;
      if (take_end)   end_blk   <= norm_blk;
      if (launch) begin
        erase_first <= start_blk;
        erase_last  <= end_blk;
      end
    end
  end
endmodule

// File: rtl/erase_wp_scan.sv
module erase_wp_scan #(
  parameter int BLK_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [BLK_W-1:0] first_blk,
  input  logic [BLK_W-1:0] last_blk,
  input  logic             wp_hit,
  input  logic             erase_done,
  output logic [BLK_W-1:0] wp_addr,
  output logic             skip_set,
  output logic             skip_valid,
  output logic [BLK_W-1:0] skip_blk,
  output logic             busy
);
  logic             scan_act;
  logic [BLK_W-1:0] cur_q, last_q;

  assign wp_addr  = cur_q;
  assign skip_set = scan_act && wp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_act   <= 1'b0;
      cur_q      <= '0;
      last_q     <= '0;
      busy       <= 1'b0;
      skip_valid <= 1'b0;
      skip_blk   <= '0;
    end else begin
      skip_valid <= 1'b0;
      if (launch) begin
        busy     <= 1'b1;
        cur_q    <= first_blk;
        last_q   <= last_blk;
        scan_act <= (first_blk <= last_blk);
      end else if (scan_act) begin
        if (wp_hit) begin
          skip_valid <= 1'b1;
          skip_blk   <= cur_q;
        end
        if (cur_q == last_q) scan_act <= 1'b0;
        else                 cur_q    <= cur_q + 1'b1;
      end else if (busy && erase_done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/erase_status_flags.sv
module erase_status_flags #(
  parameter int NFLAGS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] set_vec,
  input  logic              clr,
  output logic [NFLAGS-1:0] flags
);
  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[g] <= 1'b0;
      else if (set_vec[g]) flags[g] <= 1'b1;
      else if (clr)        flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int ARG_W   = 32,
  parameter int BLK_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [5:0]         cmd_index,
  input  logic [ARG_W-1:0]   cmd_arg,
  input  logic [SHIFT_W-1:0] blk_len_log2,
  output logic [BLK_W-1:0]   wp_addr,
  input  logic               wp_hit,
  input  logic               erase_done,
  output logic               erase_req,
  output logic [BLK_W-1:0]   erase_first,
  output logic [BLK_W-1:0]   erase_last,
  output logic               cmd_exec,
  output logic               busy,
  output logic               skip_valid,
  output logic [BLK_W-1:0]   skip_blk,
  output logic               stat_seq_err,
  output logic               stat_erase_rst,
  output logic               stat_wp_skip
);
  logic [BLK_W-1:0]  norm_blk, start_blk, end_blk;
  logic              launch, set_seq_err, set_erase_rst, status_clr, skip_set;
  logic [NFLAGS-1:0] set_vec, flags;

  erase_addr_norm #(.ARG_W(ARG_W), .BLK_W(BLK_W), .SHIFT_W(SHIFT_W)) u_norm (
    .byte_addr(cmd_arg), .shift(blk_len_log2), .blk_idx(norm_blk)
  );

  erase_seq_fsm #(.BLK_W(BLK_W)) u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .norm_blk(norm_blk), .busy(busy), .launch(launch),
    .start_blk(start_blk), .end_blk(end_blk),
    .set_seq_err(set_seq_err), .set_erase_rst(set_erase_rst),
    .status_clr(status_clr), .erase_req(erase_req),
    .erase_first(erase_first), .erase_last(erase_last), .cmd_exec(cmd_exec)
  );

  erase_wp_scan #(.BLK_W(BLK_W)) u_scan (
    .clk(clk), .rst(rst), .launch(launch), .first_blk(start_blk),
    .last_blk(end_blk), .wp_hit(wp_hit), .erase_done(erase_done),
    .wp_addr(wp_addr), .skip_set(skip_set), .skip_valid(skip_valid),
    .skip_blk(skip_blk), .busy(busy)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_SEQ]  = set_seq_err;
    set_vec[FLAG_RST]  = set_erase_rst;
    set_vec[FLAG_SKIP] = skip_set;
  end

  erase_status_flags #(.NFLAGS(NFLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr(status_clr), .flags(flags)
  );

  assign stat_seq_err   = flags[FLAG_SEQ];
  assign stat_erase_rst = flags[FLAG_RST];
  assign stat_wp_skip   = flags[FLAG_SKIP];
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [5:0] cmd_index,
  input logic       erase_done,
  input logic       erase_req,
  input logic       cmd_exec,
  input logic       busy,
  input logic       skip_valid,
  input logic       stat_seq_err,
  input logic       stat_erase_rst
);
  // R1
  req_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> busy);

  // R2
  seq_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_seq_err) |-> $past(cmd_valid) &&
      ($past(cmd_index) == 6'd32 || $past(cmd_index) == 6'd33 || $past(cmd_index) == 6'd38));

  // R3
  erase_rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_erase_rst) |-> $past(cmd_valid) &&
      $past(cmd_index) != 6'd13 && $past(cmd_index) != 6'd32 &&
      $past(cmd_index) != 6'd33 && $past(cmd_index) != 6'd38);

  // R3
  exec_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_exec |-> $past(cmd_valid) && $past(cmd_index) != 6'd32 &&
      $past(cmd_index) != 6'd33 && $past(cmd_index) != 6'd38);

  // R4
  poll_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid && cmd_index == 6'd13) |-> !stat_seq_err && !stat_erase_rst);

  // R6
  skip_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    skip_valid |-> busy);

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(erase_done));

  // R8
  no_req_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> !$past(busy));
endmodule

bind erase_seq_ctrl erase_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
  .erase_done(erase_done), .erase_req(erase_req), .cmd_exec(cmd_exec),
  .busy(busy), .skip_valid(skip_valid), .stat_seq_err(stat_seq_err),
  .stat_erase_rst(stat_erase_rst)
);

// File: tb/tb_erase_seq_ctrl.sv
module tb_erase_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [3:0]  blk_len_log2 = 4'd9;
  logic [31:0] wp_addr;
  logic        wp_hit;
  logic        erase_done = 1'b0;
  logic        erase_req, cmd_exec, busy, skip_valid;
  logic [31:0] erase_first, erase_last, skip_blk;
  logic        stat_seq_err, stat_erase_rst, stat_wp_skip;

  int total = 0;
  int bad = 0;
  int skip_n = 0;
  logic [31:0] skip_log [16];
  bit finished = 0;

  always #4 clk = ~clk;

  assign wp_hit = (wp_addr == 32'd5) || (wp_addr == 32'd7);

  erase_seq_ctrl dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .blk_len_log2(blk_len_log2), .wp_addr(wp_addr),
    .wp_hit(wp_hit), .erase_done(erase_done), .erase_req(erase_req),
    .erase_first(erase_first), .erase_last(erase_last), .cmd_exec(cmd_exec),
    .busy(busy), .skip_valid(skip_valid), .skip_blk(skip_blk),
    .stat_seq_err(stat_seq_err), .stat_erase_rst(stat_erase_rst),
    .stat_wp_skip(stat_wp_skip)
  );

  always @(negedge clk) begin
    if (skip_valid) begin
      skip_log[skip_n % 16] <= skip_blk;
      skip_n <= skip_n + 1;
    end
  end

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        err;
    logic        rsb;
    logic        exe;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{6'd33, 32'd0,    1'b1, 1'b0, 1'b0},
    '{6'd38, 32'd0,    1'b1, 1'b0, 1'b0},
    '{6'd32, 32'd1024, 1'b0, 1'b0, 1'b0},
    '{6'd32, 32'd0,    1'b1, 1'b0, 1'b0},
    '{6'd32, 32'd0,    1'b0, 1'b0, 1'b0},
    '{6'd17, 32'd0,    1'b0, 1'b1, 1'b1},
    '{6'd17, 32'd0,    1'b0, 1'b0, 1'b1},
    '{6'd32, 32'd0,    1'b0, 1'b0, 1'b0},
    '{6'd13, 32'd0,    1'b0, 1'b0, 1'b1},
    '{6'd33, 32'd4096, 1'b0, 1'b0, 1'b0},
    '{6'd32, 32'd0,    1'b1, 1'b0, 1'b0},
    '{6'd32, 32'd0,    1'b0, 1'b0, 1'b0},
    '{6'd33, 32'd0,    1'b0, 1'b0, 1'b0},
    '{6'd24, 32'd0,    1'b0, 1'b1, 1'b1},
    '{6'd38, 32'd0,    1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_index = idx;
    cmd_arg   = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 busy", busy, 0);
    chk("R9 flags", {stat_seq_err, stat_erase_rst, stat_wp_skip}, 0);
    chk("R9 req", erase_req, 0);

    // table walk: R2 R3 R4 ordering cases, poll between each vector
    for (int i = 0; i < 15; i++) begin
      send(VEC[i].idx, VEC[i].arg);
      chk($sformatf("R2 seq_err vec%0d", i), stat_seq_err, VEC[i].err);
      chk($sformatf("R3 erase_rst vec%0d", i), stat_erase_rst, VEC[i].rsb);
      chk($sformatf("R3 exec vec%0d", i), cmd_exec, VEC[i].exe);
      chk($sformatf("R1 no req vec%0d", i), erase_req, 0);
      send(6'd13, 32'd0);
      chk($sformatf("R4 cleared vec%0d", i), {stat_seq_err, stat_erase_rst}, 0);
    end

    // R1 R5 R6: erase blocks 4..8 at 512-byte blocks, 5 and 7 protected
    blk_len_log2 = 4'd9;
    base = skip_n;
    send(6'd32, 32'd4 * 512 + 32'd100);
    send(6'd13, 32'd0);
    send(6'd33, 32'd8 * 512 + 32'd511);
    send(6'd38, 32'd0);
    chk("R1 req", erase_req, 1);
    chk("R5 first", erase_first, 32'd4);
    chk("R5 last", erase_last, 32'd8);
    chk("R7 busy rise", busy, 1);
    @(negedge clk);
    chk("R1 req single", erase_req, 0);
    repeat (8) @(negedge clk);
    chk("R6 skip count", skip_n - base, 2);
    chk("R6 skip first", skip_log[base % 16], 32'd5);
    chk("R6 skip second", skip_log[(base + 1) % 16], 32'd7);
    chk("R6 skip flag", stat_wp_skip, 1);
    chk("R7 busy held", busy, 1);
    // R8 erase-class command while busy
    send(6'd32, 32'd0);
    chk("R8 seq_err", stat_seq_err, 1);
    chk("R8 no req", erase_req, 0);
    send(6'd13, 32'd0);
    chk("R6 skip flag cleared", stat_wp_skip, 0);
    chk("R7 busy before done", busy, 1);
    pulse_done();
    chk("R7 busy falls", busy, 0);
    pulse_done();
    chk("R7 idle done no effect", busy, 0);

    // R5 R7: 1024-byte blocks, blocks 2..6, early done ignored
    blk_len_log2 = 4'd10;
    base = skip_n;
    send(6'd32, 32'd2048 + 32'd1000);
    send(6'd33, 32'd6 * 1024 + 32'd3);
    send(6'd38, 32'd0);
    chk("R5 first 1k", erase_first, 32'd2);
    chk("R5 last 1k", erase_last, 32'd6);
    pulse_done();
    repeat (8) @(negedge clk);
    chk("R7 early done ignored", busy, 1);
    chk("R6 skip count 1k", skip_n - base, 1);
    chk("R6 skip blk 1k", skip_log[base % 16], 32'd5);
    pulse_done();
    chk("R7 busy falls 1k", busy, 0);
    send(6'd13, 32'd0);

    // R9 reset between start and end
    send(6'd32, 32'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 flags after reset", {stat_seq_err, stat_erase_rst, stat_wp_skip}, 0);
    send(6'd33, 32'd0);
    chk("R9 sequence cleared", stat_seq_err, 1);

    finish_run();
  end
endmodule